// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses which frame DMA channel may move data next. There are eight channels in the default build. Channels 0 to 5 carry frames toward the switch core (injection). Channels 6 and 7 carry frames away from it (extraction). Every channel belongs to one of two CPU ports. Each injection channel has a one-bit configuration that names its port. Each extraction channel is fixed to one port.

The arbiter looks at channels that are both enabled and requesting. It finds the best candidate on each port separately. It then picks one port, alternating between ports whenever both have work. The grant is registered and has a single owner at a time. The owner keeps the grant until its frame ends or it is disabled. After that the grant is idle for one cycle, and on the following cycle arbitration runs again.

Data movement, descriptors and memory access stay with the surrounding DMA engine. The engine follows the one-hot grant, the channel index and the port reported here.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After a synchronous active-high reset, `grant_o` is all zero and `grant_idx_o` and `grant_port_o` are 0. The first contended port choice then favours port 0.
- R2: While idle, if at least one channel is eligible (enabled and requesting) on the sampled clock edge, the grant for the winner appears at that edge. If no channel is eligible, the outputs stay zero.
- R3: A channel whose enable bit is 0 is never granted, whatever its request line does.
- R4: On one port, an eligible extraction channel wins over every eligible injection channel mapped to that port.
- R5: Among eligible injection channels mapped to the same port, the one with the highest channel number wins.
- R6: Port mapping follows fixed rules. Bit i of `inj_port_sel_i` set to 0 maps injection channel i to port 0, and set to 1 maps it to port 1. Channel 6 is always on port 0 and channel 7 is always on port 1. `grant_port_o` reports the port of the granted channel.
- R7: A grant is held while its channel stays enabled, regardless of its request line. When the owner's `ch_eof_i` bit is 1 at a clock edge, the grant goes to zero at that edge, and arbitration runs on the next edge.
- R8: If the owner's enable bit is 0 at a clock edge, the grant goes to zero at that edge.
- R9: When both ports have eligible candidates, the port that was not served by the previous grant wins.
- R10: When only one port has eligible candidates, that port is served, even if it was also served last.
- R11: `grant_o` has at most one bit set. When a bit is set, `grant_idx_o` is the position of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en_i | input | 8 | Per-channel enable |
| ch_req_i | input | 8 | Per-channel request |
| ch_eof_i | input | 8 | Per-channel end-of-frame indication |
| inj_port_sel_i | input | 6 | Port choice of each injection channel (0 = port 0, 1 = port 1) |
| grant_o | output | 8 | One-hot grant, zero when idle |
| grant_idx_o | output | 3 | Index of the granted channel, 0 when idle |
| grant_port_o | output | 1 | Port of the granted channel, 0 when idle |

## Verification
Most internal faults show up at the ports within one or two cycles.

- A stuck owner state keeps `grant_o` nonzero one cycle after the owner's frame end or disable.
- An owner dropped too early shows a zero grant while the channel is still mid-frame.
- A wrong port-rotation bit does not show on the grant that records it. It shows on the next contended grant, which goes to the wrong port.
- Wrong per-port priority or mapping shows as a wrong index or port on the first grant after an idle cycle.

A behavioural model compares all three outputs on every cycle. Because of that, each fault is reported in the cycle it first becomes visible.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

  // Ownership state of the shared grant
  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } own_state_e;

endpackage

// File: rtl/dmarb_port_pick.sv
// Finds the best eligible channel mapped to one CPU port.
// Extraction channels sit above injection channels in numbering,
// so "highest index wins" gives extraction-first then higher-number-first.
module dmarb_port_pick #(
  parameter int NUM_INJ   = 6,
  parameter int NUM_PORTS = 2,
  parameter int PORT_ID   = 0,
  localparam int NCH      = NUM_INJ + NUM_PORTS,
  localparam int CW       = $clog2(NCH),
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NCH-1:0]        elig,
  input  logic [NUM_INJ*PW-1:0] inj_sel,
  output logic                  cand_vld,
  output logic [CW-1:0]         cand_idx
);

  logic [NCH-1:0] on_port;

  // Injection channels: mapped by their configuration field
  for (genvar gi = 0; gi < NUM_INJ; gi++) begin : g_inj
    assign on_port[gi] = elig[gi] && (inj_sel[gi*PW +: PW] == PW'(PORT_ID));
  end

  // Extraction channels: one per port, fixed
  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_ext
    if (gp == PORT_ID) begin : g_mine
      assign on_port[NUM_INJ+gp] = elig[NUM_INJ+gp];
    end else begin : g_other
      assign on_port[NUM_INJ+gp] = 1'b0;
    end
  end

  always_comb begin
    cand_vld = 1'b0;
    cand_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (on_port[c]) begin
        cand_vld = 1'b1;
        cand_idx = CW'(c);
      end
    end
  end

endmodule

// File: rtl/dmarb_port_rr.sv
// Round-robin choice between ports that have a candidate.
module dmarb_port_rr #(
  parameter int NUM_PORTS = 2,
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] cand_vld,
  input  logic [PW-1:0]        last_port,
  output logic                 pick_vld,
  output logic [PW-1:0]        pick_port
);

  int  p;
  logic found;

  always_comb begin
    pick_vld  = |cand_vld;
    pick_port = '0;
    found     = 1'b0;
    p         = 0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      p = (int'(last_port) + k) % NUM_PORTS;
      if (!found && cand_vld[p]) begin
        pick_port = PW'(p);
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmarb_owner.sv
// Holds the current owner until frame end or disable, then issues the next pick.
module dmarb_owner
  import dmarb_pkg::*;
#(
  parameter int NUM_INJ   = 6,
  parameter int NUM_PORTS = 2,
  localparam int NCH      = NUM_INJ + NUM_PORTS,
  localparam int CW       = $clog2(NCH),
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_eof,
  input  logic           pick_vld,
  input  logic [CW-1:0]  pick_idx,
  input  logic [PW-1:0]  pick_port,
  output logic [NCH-1:0] grant_q,
  output logic [CW-1:0]  idx_q,
  output logic [PW-1:0]  port_q,
  output logic [PW-1:0]  last_port_q
);

  own_state_e state_q;
  logic       end_of_own;

  assign end_of_own = !ch_en[idx_q] || ch_eof[idx_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= OWN_IDLE;
      grant_q     <= '0;
      idx_q       <= '0;
      port_q      <= '0;
      last_port_q <= PW'(NUM_PORTS - 1);
    end else if (state_q == OWN_BUSY) begin
      if (end_of_own) begin
        state_q <= OWN_IDLE;
        grant_q <= '0;
        idx_q   <= '0;
        port_q  <= '0;
      end
    end else if (pick_vld) begin
      state_q     <= OWN_BUSY;
      grant_q     <= NCH'(1) << pick_idx;
      idx_q       <= pick_idx;
      port_q      <= pick_port;
      last_port_q <= pick_port;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_BUSY && ch_en[idx_q] && !ch_eof[idx_q]) |=> (grant_q == $past(grant_q)));

  // R7
  eof_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_BUSY && ch_eof[idx_q]) |=> (grant_q == '0));

  // R8
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_BUSY && !ch_en[idx_q]) |=> (grant_q == '0));

  // R9
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_IDLE && pick_vld) |=> (last_port_q == port_q));

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NUM_INJ   = 6,
  parameter int NUM_PORTS = 2,
  localparam int NCH      = NUM_INJ + NUM_PORTS,
  localparam int CW       = $clog2(NCH),
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ch_en_i,
  input  logic [NCH-1:0]        ch_req_i,
  input  logic [NCH-1:0]        ch_eof_i,
  input  logic [NUM_INJ*PW-1:0] inj_port_sel_i,
  output logic [NCH-1:0]        grant_o,
  output logic [CW-1:0]         grant_idx_o,
  output logic [PW-1:0]         grant_port_o
);

  logic [NCH-1:0]       elig;
  logic [NUM_PORTS-1:0] cand_vld;
  logic [CW-1:0]        cand_idx [NUM_PORTS];
  logic                 pick_vld;
  logic [PW-1:0]        pick_port;
  logic [CW-1:0]        pick_idx;
  logic [PW-1:0]        last_port;

  assign elig = ch_en_i & ch_req_i;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    dmarb_port_pick #(
      .NUM_INJ   (NUM_INJ),
      .NUM_PORTS (NUM_PORTS),
      .PORT_ID   (gp)
    ) u_pick (
      .elig     (elig),
      .inj_sel  (inj_port_sel_i),
      .cand_vld (cand_vld[gp]),
      .cand_idx (cand_idx[gp])
    );
  end

  dmarb_port_rr #(
    .NUM_PORTS (NUM_PORTS)
  ) u_rr (
    .cand_vld  (cand_vld),
    .last_port (last_port),
    .pick_vld  (pick_vld),
    .pick_port (pick_port)
  );

  assign pick_idx = cand_idx[pick_port];

  dmarb_owner #(
    .NUM_INJ   (NUM_INJ),
    .NUM_PORTS (NUM_PORTS)
  ) u_owner (
    .clk         (clk),
    .rst         (rst),
    .ch_en       (ch_en_i),
    .ch_eof      (ch_eof_i),
    .pick_vld    (pick_vld),
    .pick_idx    (pick_idx),
    .pick_port   (pick_port),
    .grant_q     (grant_o),
    .idx_q       (grant_idx_o),
    .port_q      (grant_port_o),
    .last_port_q (last_port)
  );

  // R11
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R11
  idx_match_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |-> grant_o[grant_idx_o]);

  // R3
  granted_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0) |=> ((grant_o == '0) || ((grant_o & $past(elig)) != '0)));

  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0 && elig == '0) |=> (grant_o == '0));

  // R6
  ext_port_chk: assert property (@(posedge clk) disable iff (rst)
    grant_o[NUM_INJ] |-> (grant_port_o == '0));

endmodule

// File: tb/dma_chan_arbiter_bench.sv
module dma_chan_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ch_en = '0;
  logic [7:0] ch_req = '0;
  logic [7:0] ch_eof = '0;
  logic [5:0] sel = '0;
  logic [7:0] grant;
  logic [2:0] gidx;
  logic       gport;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    model_on = 0;
  string cur_tag = "R1";

  // Reference model state
  int m_owner = -1;
  int m_port  = 0;
  int m_last  = 1;
  int best0, best1, chosen;

  always #4 clk = ~clk;

  dma_chan_arbiter u_dma_chan_arbiter (
    .clk            (clk),
    .rst            (rst),
    .ch_en_i        (ch_en),
    .ch_req_i       (ch_req),
    .ch_eof_i       (ch_eof),
    .inj_port_sel_i (sel),
    .grant_o        (grant),
    .grant_idx_o    (gidx),
    .grant_port_o   (gport)
  );

  function automatic int port_of(int c);
    if (c < 6) return int'(sel[c]);
    return c - 6;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_owner = -1; m_port = 0; m_last = 1;
    end else if (m_owner >= 0) begin
      if (!ch_en[m_owner] || ch_eof[m_owner]) m_owner = -1;
    end else begin
      best0 = -1; best1 = -1;
      for (int c = 0; c < 8; c++) begin
        if (ch_en[c] && ch_req[c]) begin
          if (port_of(c) == 0) best0 = c; else best1 = c;
        end
      end
      chosen = -1;
      if (best0 >= 0 && best1 >= 0) chosen = (m_last == 0) ? 1 : 0;
      else if (best0 >= 0) chosen = 0;
      else if (best1 >= 0) chosen = 1;
      if (chosen >= 0) begin
        m_owner = (chosen == 0) ? best0 : best1;
        m_port  = chosen;
        m_last  = chosen;
      end
    end
  end

  function automatic logic [7:0] exp_grant();
    return (m_owner >= 0) ? (8'b1 << m_owner) : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (model_on && !done) begin
      logic [7:0] eg;
      int ei, ep;
      eg = exp_grant();
      ei = (m_owner >= 0) ? m_owner : 0;
      ep = (m_owner >= 0) ? m_port : 0;
      checks++;
      if (grant !== eg || int'(gidx) != ei || int'(gport) != ep) begin
        errors++;
        $display("FAIL %s (model) actual grant=%h idx=%0d port=%0d expected grant=%h idx=%0d port=%0d",
                 cur_tag, grant, gidx, gport, eg, ei, ep);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] eg, int ei, int ep);
    checks++;
    if (grant !== eg || int'(gidx) != ei || int'(gport) != ep) begin
      errors++;
      $display("FAIL %s actual grant=%h idx=%0d port=%0d expected grant=%h idx=%0d port=%0d",
               tag, grant, gidx, gport, eg, ei, ep);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    model_on = 1;
    // R1: reset state
    chk("R1", 8'h00, 0, 0);

    // R3: disabled channel with request is ignored
    cur_tag = "R3";
    ch_en = 8'hF7; ch_req = 8'h08;
    tick(); tick();
    chk("R3", 8'h00, 0, 0);
    ch_req = 8'h00; ch_en = 8'hFF;
    tick();

    // R5, R2: channels 1 and 4 on port 0 -> channel 4, one edge later
    cur_tag = "R5";
    ch_req = 8'h12;
    tick();
    chk("R5", 8'h10, 4, 0);

    // R7: hold without request
    cur_tag = "R7";
    ch_req = 8'h00;
    tick();
    chk("R7", 8'h10, 4, 0);
    ch_eof = 8'h10;
    tick();
    chk("R7", 8'h00, 0, 0);
    ch_eof = 8'h00;
    tick();
    // R2: nothing eligible, stays idle
    chk("R2", 8'h00, 0, 0);

    // R4, R10: extraction ch6 beats injection ch5 on port 0; port 0 served again
    cur_tag = "R4";
    ch_req = 8'h60;
    tick();
    chk("R4", 8'h40, 6, 0);
    chk("R10", 8'h40, 6, 0);
    ch_req = 8'h00; ch_eof = 8'h40;
    tick();
    ch_eof = 8'h00;

    // R6: injection ch2 mapped to port 1
    cur_tag = "R6";
    sel = 6'b000100; ch_req = 8'h04;
    tick();
    chk("R6", 8'h04, 2, 1);
    ch_req = 8'h00; ch_eof = 8'h04;
    tick();
    ch_eof = 8'h00;

    // R9: last served port 1, both ports contend -> port 0 first
    cur_tag = "R9";
    ch_req = 8'h88;
    tick();
    chk("R9", 8'h08, 3, 0);
    ch_eof = 8'h08;
    tick();
    chk("R7", 8'h00, 0, 0);
    ch_eof = 8'h00;
    tick();
    chk("R9", 8'h80, 7, 1);

    // R8: owner disabled mid-frame
    cur_tag = "R8";
    ch_en = 8'h7F;
    tick();
    chk("R8", 8'h00, 0, 0);
    tick();
    chk("R3", 8'h08, 3, 0);
    ch_req = 8'h00; ch_en = 8'hFF; ch_eof = 8'h08;
    tick();
    ch_eof = 8'h00;

    // Mixed random traffic against the model (R11 and all others)
    cur_tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      ch_req = 8'($urandom);
      ch_en  = 8'($urandom | $urandom);
      ch_eof = 8'($urandom & $urandom & $urandom);
      if ((i % 50) == 0) sel = 6'($urandom);
      tick();
    end
    ch_req = 8'h00; ch_eof = 8'h00;
    tick(); tick();
    finish_run();
  end

endmodule